// File: doc/BRIEF.md
# Motion-Compensation Command Parser

This block sits at the front of a macroblock motion-compensation engine. It takes a stream of 32-bit command words through a valid/ready input port. For each command it produces one decoded macroblock descriptor on a valid/ready output port.

The first word of a command is the header. Its low three bits give the prediction mode, and its top six bits say which of the six blocks carry residual data. The mode sets how many parameter words follow and what each one means. The parser counts the words and stores each one in its descriptor field. When the last word arrives it presents the descriptor and holds it until the consumer takes it. Any header with bit 2 set marks the end of the list. The parser then stops and waits for a restart pulse.

Top module: `mc_cmd_parser`

## Requirements
- R1: After reset `in_ready_o` is 1, `out_valid_o` is 0 and `done_o` is 0.
- R2: Header bits 2:0 give the mode: 0 intra, 1 forward, 2 backward, 3 bidirectional. `out_mode_o` carries bits 1:0. Header bits 31..26 appear on `out_blk_o[5..0]` in the order Y0, Y1, Y2, Y3, U, V, where 1 means residual data is present. Header bits 25:3 are ignored.
- R3: An intra command is the header, column, row and buffer pointer (4 words). All four offset outputs read zero.
- R4: A forward command is the header, column, row, forward vertical offset, forward horizontal offset and buffer pointer (6 words). Both backward offsets read zero.
- R5: A backward command has the forward layout, but words 4 and 5 are the backward vertical and horizontal offsets. Both forward offsets read zero.
- R6: A bidirectional command is the header, column, row, forward vertical, forward horizontal, backward vertical and backward horizontal offsets, then the buffer pointer (8 words).
- R7: A header with bit 2 set is an end command whatever bits 1:0 hold. It has no parameter words, raises `done_o` and produces no descriptor.
- R8: While `done_o` is 1, `in_ready_o` is 0 and input words are refused. A one-cycle `restart_i` pulse clears `done_o` and makes the parser expect a header again.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, every descriptor output holds its value and `in_ready_o` is 0.
- R10: The descriptor is issued exactly once. The cycle after it is taken, `out_valid_o` is 0 and the next header is accepted.
- R11: Cycles with `in_valid_i` low do not advance parsing, so gaps between words do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Leaves the done state |
| in_valid_i | input | 1 | Command word valid |
| in_data_i | input | 32 | Command word |
| in_ready_o | output | 1 | Parser can take a word |
| out_valid_o | output | 1 | Descriptor valid |
| out_ready_i | input | 1 | Consumer takes the descriptor |
| out_mode_o | output | 2 | Prediction mode |
| out_blk_o | output | 6 | Block-present flags Y0..V (bit 5..0) |
| out_col_o | output | 32 | Macroblock column |
| out_row_o | output | 32 | Macroblock row |
| out_fwd_v_o | output | 32 | Forward vertical offset |
| out_fwd_h_o | output | 32 | Forward horizontal offset |
| out_bwd_v_o | output | 32 | Backward vertical offset |
| out_bwd_h_o | output | 32 | Backward horizontal offset |
| out_bufptr_o | output | 32 | Buffer RAM pointer |
| done_o | output | 1 | End command seen |

## Verification
The hold and zero-field assertions assume that the consumer only takes a descriptor through `out_ready_i`, and that reset is the only other way out of the output state. The bench meets this by raising `out_ready_i` only while it checks a presented descriptor. It pulses `restart_i` only in the done state. It sends a bidirectional command with every field nonzero before the intra, forward and backward commands, so a field that was not cleared would show up.

// File: rtl/mc_cmd_pkg.sv
package mc_cmd_pkg;
  localparam int BLK_W      = 6;
  localparam int MAX_PARAMS = 7;
  localparam int IDX_W      = $clog2(MAX_PARAMS);
  localparam int NUM_SLOTS  = 7;

  typedef enum logic [1:0] {
    MB_INTRA = 2'd0,
    MB_FWD   = 2'd1,
    MB_BWD   = 2'd2,
    MB_BI    = 2'd3
  } mb_mode_e;

  typedef enum logic [2:0] {
    SLOT_COL = 3'd0,
    SLOT_ROW = 3'd1,
    SLOT_FV  = 3'd2,
    SLOT_FH  = 3'd3,
    SLOT_BV  = 3'd4,
    SLOT_BH  = 3'd5,
    SLOT_PTR = 3'd6
  } slot_e;

  function automatic logic [IDX_W-1:0] param_count(mb_mode_e m);
    case (m)
      MB_INTRA: param_count = IDX_W'(3);
      MB_FWD,
      MB_BWD:   param_count = IDX_W'(5);
      default:  param_count = IDX_W'(7);
    endcase
  endfunction

  // destination field of parameter word idx (0 = first word after header)
  function automatic slot_e slot_of(mb_mode_e m, logic [IDX_W-1:0] idx);
    slot_e s;
    s = SLOT_PTR;
    if (idx == IDX_W'(0))      s = SLOT_COL;
    else if (idx == IDX_W'(1)) s = SLOT_ROW;
    else begin
      case (m)
        MB_FWD: begin
          if (idx == IDX_W'(2))      s = SLOT_FV;
          else if (idx == IDX_W'(3)) s = SLOT_FH;
        end
        MB_BWD: begin
          if (idx == IDX_W'(2))      s = SLOT_BV;
          else if (idx == IDX_W'(3)) s = SLOT_BH;
        end
        MB_BI: begin
          if (idx == IDX_W'(2))      s = SLOT_FV;
          else if (idx == IDX_W'(3)) s = SLOT_FH;
          else if (idx == IDX_W'(4)) s = SLOT_BV;
          else if (idx == IDX_W'(5)) s = SLOT_BH;
        end
        default: s = SLOT_PTR;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/mc_hdr_decode.sv
module mc_hdr_decode
  import mc_cmd_pkg::*;
(
  input  logic [BLK_W-1:0] flags_i,
  input  logic [2:0]       mode_bits_i,
  output logic             is_end_o,
  output mb_mode_e         mode_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [IDX_W-1:0] nparam_o
);
  assign is_end_o = mode_bits_i[2];
  assign mode_o   = mb_mode_e'(mode_bits_i[1:0]);
  assign blk_o    = flags_i;
  assign nparam_o = param_count(mb_mode_e'(mode_bits_i[1:0]));
endmodule

// File: rtl/mc_param_store.sv
module mc_param_store
  import mc_cmd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              wr_i,
  input  mb_mode_e                          mode_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [WORD_W-1:0]                 data_i,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0]  fields_o
);
  slot_e wr_slot;
  assign wr_slot = slot_of(mode_i, idx_i);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     fields_o[g] <= '0;
      else if (clear_i)                                fields_o[g] <= '0;
      else if (wr_i && (wr_slot == slot_e'(3'(g))))    fields_o[g] <= data_i;
    end
  end

  AST_NO_WRITE_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_i && wr_i)); // R10
endmodule

// File: rtl/mc_seq_fsm.sv
module mc_seq_fsm
  import mc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             in_valid_i,
  input  logic             hdr_end_i,
  input  mb_mode_e         hdr_mode_i,
  input  logic [BLK_W-1:0] hdr_blk_i,
  input  logic [IDX_W-1:0] hdr_nparam_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             done_o,
  output logic             load_hdr_o,
  output logic             wr_param_o,
  output logic [IDX_W-1:0] idx_o,
  output mb_mode_e         mode_o,
  output logic [BLK_W-1:0] blk_o
);
  typedef enum logic [1:0] {ST_HDR, ST_PARAM, ST_OUT, ST_DONE} state_e;

  state_e           state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             accept;

  assign in_ready_o  = (state_q == ST_HDR) || (state_q == ST_PARAM);
  assign out_valid_o = (state_q == ST_OUT);
  assign done_o      = (state_q == ST_DONE);
  assign accept      = in_valid_i && in_ready_o;
  assign load_hdr_o  = accept && (state_q == ST_HDR) && !hdr_end_i;
  assign wr_param_o  = accept && (state_q == ST_PARAM);
  assign idx_o       = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      idx_q   <= '0;
      last_q  <= '0;
      mode_o  <= MB_INTRA;
      blk_o   <= '0;
    end else begin
      case (state_q)
        ST_HDR: if (accept) begin
          if (hdr_end_i) state_q <= ST_DONE;
          else begin
            state_q <= ST_PARAM;
            idx_q   <= '0;
            last_q  <= hdr_nparam_i - IDX_W'(1);
            mode_o  <= hdr_mode_i;
            blk_o   <= hdr_blk_i;
          end
        end
        ST_PARAM: if (accept) begin
          if (idx_q == last_q) state_q <= ST_OUT;
          else                 idx_q   <= idx_q + IDX_W'(1);
        end
        ST_OUT:  if (out_ready_i) state_q <= ST_HDR;
        ST_DONE: if (restart_i)   state_q <= ST_HDR;
        default: state_q <= ST_HDR;
      endcase
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARAM) |-> (idx_q <= last_q)); // R10
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!in_ready_o && !out_valid_o)); // R8
  AST_DONE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> done_o); // R8
  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o); // R9
  AST_IN_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o)); // R9
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> !out_valid_o); // R10
  AST_END_NO_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !out_valid_o && in_valid_i && hdr_end_i && (idx_q == idx_q) && !wr_param_o)
      |=> (done_o && !out_valid_o)); // R7
endmodule

// File: rtl/mc_cmd_parser.sv
module mc_cmd_parser
  import mc_cmd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [1:0]        out_mode_o,
  output logic [BLK_W-1:0]  out_blk_o,
  output logic [WORD_W-1:0] out_col_o,
  output logic [WORD_W-1:0] out_row_o,
  output logic [WORD_W-1:0] out_fwd_v_o,
  output logic [WORD_W-1:0] out_fwd_h_o,
  output logic [WORD_W-1:0] out_bwd_v_o,
  output logic [WORD_W-1:0] out_bwd_h_o,
  output logic [WORD_W-1:0] out_bufptr_o,
  output logic              done_o
);
  logic                             hdr_end;
  mb_mode_e                         hdr_mode, cur_mode;
  logic [BLK_W-1:0]                 hdr_blk;
  logic [IDX_W-1:0]                 hdr_nparam, idx;
  logic                             load_hdr, wr_param;
  logic [NUM_SLOTS-1:0][WORD_W-1:0] fields;

  mc_hdr_decode u_dec (
    .flags_i    (in_data_i[WORD_W-1 -: BLK_W]),
    .mode_bits_i(in_data_i[2:0]),
    .is_end_o   (hdr_end),
    .mode_o     (hdr_mode),
    .blk_o      (hdr_blk),
    .nparam_o   (hdr_nparam)
  );

  mc_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .in_valid_i  (in_valid_i),
    .hdr_end_i   (hdr_end),
    .hdr_mode_i  (hdr_mode),
    .hdr_blk_i   (hdr_blk),
    .hdr_nparam_i(hdr_nparam),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .done_o      (done_o),
    .load_hdr_o  (load_hdr),
    .wr_param_o  (wr_param),
    .idx_o       (idx),
    .mode_o      (cur_mode),
    .blk_o       (out_blk_o)
  );

  mc_param_store #(.WORD_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_hdr),
    .wr_i    (wr_param),
    .mode_i  (cur_mode),
    .idx_i   (idx),
    .data_i  (in_data_i),
    .fields_o(fields)
  );

  assign out_mode_o   = cur_mode;
  assign out_col_o    = fields[SLOT_COL];
  assign out_row_o    = fields[SLOT_ROW];
  assign out_fwd_v_o  = fields[SLOT_FV];
  assign out_fwd_h_o  = fields[SLOT_FH];
  assign out_bwd_v_o  = fields[SLOT_BV];
  assign out_bwd_h_o  = fields[SLOT_BH];
  assign out_bufptr_o = fields[SLOT_PTR];

  AST_DESC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> ($stable(out_col_o) && $stable(out_row_o) &&
      $stable(out_fwd_v_o) && $stable(out_fwd_h_o) && $stable(out_bwd_v_o) &&
      $stable(out_bwd_h_o) && $stable(out_bufptr_o) && $stable(out_mode_o) &&
      $stable(out_blk_o))); // R9
  AST_INTRA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_mode_o == 2'd0) |->
      (out_fwd_v_o == '0 && out_fwd_h_o == '0 && out_bwd_v_o == '0 && out_bwd_h_o == '0)); // R3
  AST_FWD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_mode_o == 2'd1) |-> (out_bwd_v_o == '0 && out_bwd_h_o == '0)); // R4
  AST_BWD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_mode_o == 2'd2) |-> (out_fwd_v_o == '0 && out_fwd_h_o == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i && !out_valid_o) |=> ($stable(out_col_o) && $stable(out_bufptr_o))); // R11
endmodule

// File: tb/tb_mc_cmd_parser.sv
module tb_mc_cmd_parser;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        restart_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o, out_valid_o, done_o;
  logic        out_ready_i = 1'b0;
  logic [1:0]  out_mode_o;
  logic [5:0]  out_blk_o;
  logic [31:0] out_col_o, out_row_o, out_fwd_v_o, out_fwd_h_o;
  logic [31:0] out_bwd_v_o, out_bwd_h_o, out_bufptr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mc_cmd_parser dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // called at a negedge; returns at the negedge after the word is taken
  task automatic send_word(logic [31:0] w);
    in_valid_i = 1'b1;
    in_data_i  = w;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_data_i  = 32'hDEAD_BEEF;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic run_cmd(string tag, logic [1:0] mode, logic [5:0] blk,
                         logic [31:0] col, row, fv, fh, bv, bh, ptr,
                         int gap, int hold);
    logic [31:0] w [8];
    int n;
    w[0] = {blk, 23'h5A5A5, 1'b0, mode};
    w[1] = col;
    w[2] = row;
    case (mode)
      2'd0: begin w[3] = ptr; n = 4; end
      2'd1: begin w[3] = fv; w[4] = fh; w[5] = ptr; n = 6; end
      2'd2: begin w[3] = bv; w[4] = bh; w[5] = ptr; n = 6; end
      default: begin w[3] = fv; w[4] = fh; w[5] = bv; w[6] = bh; w[7] = ptr; n = 8; end
    endcase
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i == n - 1) begin
        idle(gap);
        chk({tag, " R11 no early valid"}, {31'b0, out_valid_o}, 32'd0);
        chk({tag, " R11 still ready"}, {31'b0, in_ready_o}, 32'd1);
      end
      send_word(w[i]);
    end
    chk({tag, " R10 valid"}, {31'b0, out_valid_o}, 32'd1);
    chk({tag, " R2 mode"}, {30'b0, out_mode_o}, {30'b0, mode});
    chk({tag, " R2 blk"}, {26'b0, out_blk_o}, {26'b0, blk});
    chk({tag, " col"}, out_col_o, col);
    chk({tag, " row"}, out_row_o, row);
    chk({tag, " fwd_v"}, out_fwd_v_o, (mode == 2'd1 || mode == 2'd3) ? fv : 32'd0);
    chk({tag, " fwd_h"}, out_fwd_h_o, (mode == 2'd1 || mode == 2'd3) ? fh : 32'd0);
    chk({tag, " bwd_v"}, out_bwd_v_o, (mode == 2'd2 || mode == 2'd3) ? bv : 32'd0);
    chk({tag, " bwd_h"}, out_bwd_h_o, (mode == 2'd2 || mode == 2'd3) ? bh : 32'd0);
    chk({tag, " ptr"}, out_bufptr_o, ptr);
    if (hold > 0) begin
      in_valid_i = 1'b1;
      in_data_i  = 32'h0000_0001;
      idle(hold);
      chk({tag, " R9 held valid"}, {31'b0, out_valid_o}, 32'd1);
      chk({tag, " R9 in_ready low"}, {31'b0, in_ready_o}, 32'd0);
      chk({tag, " R9 col held"}, out_col_o, col);
      chk({tag, " R9 ptr held"}, out_bufptr_o, ptr);
      in_valid_i = 1'b0;
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    chk({tag, " R10 valid drops"}, {31'b0, out_valid_o}, 32'd0);
    chk({tag, " R10 ready again"}, {31'b0, in_ready_o}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 in_ready", {31'b0, in_ready_o}, 32'd1);
    chk("R1 out_valid", {31'b0, out_valid_o}, 32'd0);
    chk("R1 done", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_end(logic [2:0] code, logic [31:0] upper);
    send_word(upper | {29'b0, code});
    chk("R7 done set", {31'b0, done_o}, 32'd1);
    chk("R7 no descriptor", {31'b0, out_valid_o}, 32'd0);
    in_valid_i = 1'b1;
    in_data_i  = 32'h0000_0000;
    idle(3);
    chk("R8 refuses input", {31'b0, in_ready_o}, 32'd0);
    chk("R8 done held", {31'b0, done_o}, 32'd1);
    chk("R8 no output", {31'b0, out_valid_o}, 32'd0);
    in_valid_i = 1'b0;
    restart_i = 1'b1;
    @(negedge clk_i);
    restart_i = 1'b0;
    chk("R8 restart clears done", {31'b0, done_o}, 32'd0);
    chk("R8 restart ready", {31'b0, in_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_cmd("R6 bidir", 2'd3, 6'b111111, 32'h11, 32'h22, 32'h33, 32'h44, 32'h55, 32'h66, 32'h77, 0, 0);
    run_cmd("R3 intra", 2'd0, 6'b101010, 32'h1A, 32'h2B, 32'h99, 32'h98, 32'h97, 32'h96, 32'h3C, 0, 2);
    run_cmd("R6 bidir2", 2'd3, 6'b010101, 32'hA1, 32'hA2, 32'hA3, 32'hA4, 32'hA5, 32'hA6, 32'hA7, 0, 0);
    run_cmd("R4 fwd", 2'd1, 6'b100001, 32'h101, 32'h202, 32'hFFFF_FFF0, 32'h10, 32'h55, 32'h56, 32'h303, 2, 3);
    run_cmd("R6 bidir3", 2'd3, 6'b000011, 32'hB1, 32'hB2, 32'hB3, 32'hB4, 32'hB5, 32'hB6, 32'hB7, 1, 0);
    run_cmd("R5 bwd", 2'd2, 6'b011110, 32'h404, 32'h505, 32'h77, 32'h78, 32'h8, 32'hFFFF_FFF8, 32'h606, 0, 1);
    t_end(3'd4, 32'h0);
    run_cmd("R6 after restart", 2'd3, 6'b110000, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7, 3, 0);
    t_end(3'd7, 32'hFC00_0000);
    run_cmd("R3 intra2", 2'd0, 6'b000000, 32'h0, 32'hFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'hABCD, 0, 0);
    finish_run();
  end
endmodule